// File: doc/BRIEF.md
# PHY Control-Register Access Bridge

This block gives a host CPU access to the 16-bit internal control-register space of a USB 3 PHY. The PHY exposes that space only through an indirect handshake port: an address capture, a data capture, a read and a write, each raised as a request line and closed by a shared acknowledge. The bridge exposes a small memory-mapped register set. The host stages a 16-bit word in a staging register, then sets a self-clearing command bit. The bridge converts that bit into one request/acknowledge exchange on the PHY side.

A PHY write takes three commands: capture the address, capture the data, then write. A PHY read takes two: capture the address, then read. The result lands in a result register. Each command bit reads back as 1 while its exchange is in flight, so software polls it until it reads 0. The first read after an address capture can return a stale word. With `DISCARD_STALE` set, the bridge handles this itself. It runs the read exchange twice and keeps only the second answer.

The sequencer has three states:
- `ST_IDLE` waits for a command. A command moves it to `ST_REQ` (start).
- `ST_REQ` holds one request line high until the acknowledge is seen. It then moves to `ST_RELEASE` (ack seen).
- `ST_RELEASE` waits for the acknowledge to fall. It then returns to `ST_IDLE` (done), or goes back to `ST_REQ` when a stale read must be repeated (rerun).

Top module: `phy_creg_bridge`

## Requirements
- R1: After reset all four request lines are low, the result register reads 0, the staging register reads 0 and every command register reads 0.
- R2: Host byte offsets are fixed as follows:
  - staging word at 0x0C, bits 15:0, with bits 31:16 reading 0;
  - result at 0x10, bits 15:0;
  - capture-address command at 0x14;
  - capture-data command at 0x18;
  - read command at 0x1C;
  - write command at 0x20.
  Any other offset reads 0.
- R3: A host write with bit 0 set to a command offset, made while idle, raises the matching request line on the following cycle. At most one request line is ever high.
- R4: A request line stays high until the acknowledge is sampled high, and falls in the next cycle. No new request is raised until the acknowledge has been sampled low again.
- R5: A command register reads 1 from the cycle after it is set until the acknowledge has fallen for its last exchange. It then reads 0.
- R6: A command write made while any command is in flight is ignored. This includes the very cycle in which the previous exchange completes.
- R7: The staging register drives the PHY data bus. A host write to it while a command is in flight is ignored.
- R8: The result register loads the PHY read bus on the acknowledge of a kept read, and holds its value at all other times.
- R9: With `DISCARD_STALE`=1, the first read command after an address capture performs two read exchanges and keeps only the second answer. Later read commands perform a single exchange.
- R10: A host write of a value with bit 0 clear to a command offset starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 6 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational on host_addr) |
| phy_req_addr | output | 1 | Address-capture request |
| phy_req_data | output | 1 | Data-capture request |
| phy_req_rd | output | 1 | Read request |
| phy_req_wr | output | 1 | Write request |
| phy_wdata | output | 16 | Word presented to the PHY (staging register) |
| phy_rdata | input | 16 | Word returned by the PHY |
| phy_ack | input | 1 | PHY acknowledge, shared by all requests |

## Verification
Two functions can meet in the same cycle:
- the completion of an exchange, when `ST_RELEASE` samples the acknowledge low;
- the arrival of a new command from the host.

The bench provokes the collision as follows. It watches for the cycle in which the previous command register still reads 1 while both the request and the acknowledge are already low. In exactly that cycle it writes a new command. The case is judged at the ports: no request line rises afterwards, the new command register reads 0, and the PHY model counts no extra exchange.

A second overlap, a staging-register write during a long exchange, is judged by reading the staging word back and by watching the PHY data bus.

// File: rtl/creg_bridge_pkg.sv
package creg_bridge_pkg;

    localparam int unsigned HOST_AW = 6;

    localparam logic [HOST_AW-1:0] OFS_STAGE = 6'h0C;
    localparam logic [HOST_AW-1:0] OFS_RESULT = 6'h10;
    localparam logic [HOST_AW-1:0] OFS_CAPA = 6'h14;
    localparam logic [HOST_AW-1:0] OFS_CAPD = 6'h18;
    localparam logic [HOST_AW-1:0] OFS_READ = 6'h1C;
    localparam logic [HOST_AW-1:0] OFS_WRITE = 6'h20;

    typedef enum logic [1:0] {
        OP_CAPA  = 2'd0,
        OP_CAPD  = 2'd1,
        OP_READ  = 2'd2,
        OP_WRITE = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_REQ     = 2'd1,
        ST_RELEASE = 2'd2
    } state_e;

endpackage

// File: rtl/creg_regs.sv
module creg_regs
    import creg_bridge_pkg::*;
#(
    parameter int unsigned AW = 6,
    parameter int unsigned DW = 32,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          busy,
    input  op_e           op_q,
    input  logic          dout_load,
    input  logic [CW-1:0] phy_rdata,
    output logic [CW-1:0] stage_q,
    output logic          start,
    output op_e           start_op
);

    localparam int unsigned PAD = DW - CW;

    logic [CW-1:0] result_q;
    logic          is_cmd;

    always_comb begin
        is_cmd   = 1'b1;
        start_op = OP_CAPA;
        unique case (host_addr)
            OFS_CAPA:  start_op = OP_CAPA;
            OFS_CAPD:  start_op = OP_CAPD;
            OFS_READ:  start_op = OP_READ;
            OFS_WRITE: start_op = OP_WRITE;
            default:   is_cmd = 1'b0;
        endcase
    end

    assign start = host_we && is_cmd && host_wdata[0] && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q  <= '0;
            result_q <= '0;
        end else begin
            if (host_we && (host_addr == OFS_STAGE) && !busy)
                stage_q <= host_wdata[CW-1:0];
            if (dout_load)
                result_q <= phy_rdata;
        end
    end

    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            OFS_STAGE:  host_rdata = {{PAD{1'b0}}, stage_q};
            OFS_RESULT: host_rdata = {{PAD{1'b0}}, result_q};
            OFS_CAPA:   host_rdata[0] = busy && (op_q == OP_CAPA);
            OFS_CAPD:   host_rdata[0] = busy && (op_q == OP_CAPD);
            OFS_READ:   host_rdata[0] = busy && (op_q == OP_READ);
            OFS_WRITE:  host_rdata[0] = busy && (op_q == OP_WRITE);
            default:    host_rdata = '0;
        endcase
    end

    // R7
    stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(stage_q));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_load |=> $stable(result_q));

endmodule

// File: rtl/creg_seq.sv
module creg_seq
    import creg_bridge_pkg::*;
#(
    parameter bit DISCARD_STALE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  op_e  start_op,
    input  logic phy_ack,
    output logic busy,
    output op_e  op_q,
    output logic dout_load,
    output logic req_addr,
    output logic req_data,
    output logic req_rd,
    output logic req_wr
);

    state_e state_q, state_d;
    logic   stale_q;
    logic   discard_q;
    logic   ack_in_req;

    assign ack_in_req = (state_q == ST_REQ) && phy_ack;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_REQ;
            ST_REQ:     if (phy_ack) state_d = ST_RELEASE;
            ST_RELEASE: if (!phy_ack) state_d = discard_q ? ST_REQ : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            op_q      <= OP_CAPA;
            stale_q   <= 1'b0;
            discard_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                op_q      <= start_op;
                discard_q <= DISCARD_STALE && stale_q && (start_op == OP_READ);
            end
            if (state_q == ST_RELEASE && !phy_ack)
                discard_q <= 1'b0;
            if (ack_in_req && op_q == OP_CAPA)
                stale_q <= 1'b1;
            else if (dout_load)
                stale_q <= 1'b0;
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        req_addr  = (state_q == ST_REQ) && (op_q == OP_CAPA);
        req_data  = (state_q == ST_REQ) && (op_q == OP_CAPD);
        req_rd    = (state_q == ST_REQ) && (op_q == OP_READ);
        req_wr    = (state_q == ST_REQ) && (op_q == OP_WRITE);
        dout_load = ack_in_req && (op_q == OP_READ) && !discard_q;
    end

    // R3
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_addr, req_data, req_rd, req_wr}));

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_addr | req_data | req_rd | req_wr) && !phy_ack)
        |=> (req_addr | req_data | req_rd | req_wr));

    // R4
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_addr | req_data | req_rd | req_wr) && phy_ack)
        |=> !(req_addr | req_data | req_rd | req_wr));

    // R6
    no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(req_addr | req_data | req_rd | req_wr));

endmodule

// File: rtl/phy_creg_bridge.sv
module phy_creg_bridge
    import creg_bridge_pkg::*;
#(
    parameter int unsigned AW = 6,
    parameter int unsigned DW = 32,
    parameter int unsigned CW = 16,
    parameter bit DISCARD_STALE = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          phy_req_addr,
    output logic          phy_req_data,
    output logic          phy_req_rd,
    output logic          phy_req_wr,
    output logic [CW-1:0] phy_wdata,
    input  logic [CW-1:0] phy_rdata,
    input  logic          phy_ack
);

    logic busy;
    logic start;
    logic dout_load;
    op_e  op_q;
    op_e  start_op;

    creg_regs #(.AW(AW), .DW(DW), .CW(CW)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy       (busy),
        .op_q       (op_q),
        .dout_load  (dout_load),
        .phy_rdata  (phy_rdata),
        .stage_q    (phy_wdata),
        .start      (start),
        .start_op   (start_op)
    );

    creg_seq #(.DISCARD_STALE(DISCARD_STALE)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_op  (start_op),
        .phy_ack   (phy_ack),
        .busy      (busy),
        .op_q      (op_q),
        .dout_load (dout_load),
        .req_addr  (phy_req_addr),
        .req_data  (phy_req_data),
        .req_rd    (phy_req_rd),
        .req_wr    (phy_req_wr)
    );

endmodule

// File: tb/phy_creg_bridge_tb.sv
`timescale 1ns/1ps
module phy_creg_bridge_tb_top;

    localparam logic [5:0] A_STAGE = 6'h0C;
    localparam logic [5:0] A_RES = 6'h10;
    localparam logic [5:0] A_CAPA = 6'h14;
    localparam logic [5:0] A_CAPD = 6'h18;
    localparam logic [5:0] A_RD = 6'h1C;
    localparam logic [5:0] A_WR = 6'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        phy_req_addr, phy_req_data, phy_req_rd, phy_req_wr;
    logic [15:0] phy_wdata;
    logic [15:0] phy_rdata;
    logic        phy_ack;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    phy_creg_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .phy_req_addr(phy_req_addr), .phy_req_data(phy_req_data),
        .phy_req_rd(phy_req_rd), .phy_req_wr(phy_req_wr),
        .phy_wdata(phy_wdata), .phy_rdata(phy_rdata), .phy_ack(phy_ack)
    );

    // PHY model: fixed ack delay, stale answer on first read after capture
    logic [15:0] mem [0:63];
    logic [15:0] cap_a, cap_d;
    logic        stale;
    int          ack_delay = 1;
    int          dcnt = 0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic        any_req;
    assign any_req = phy_req_addr | phy_req_data | phy_req_rd | phy_req_wr;

    always @(posedge clk) begin
        if (!rst_n) begin
            phy_ack   <= 1'b0;
            phy_rdata <= '0;
            cap_a     <= '0;
            cap_d     <= '0;
            stale     <= 1'b0;
            dcnt      <= 0;
        end else if (!phy_ack && any_req) begin
            if (dcnt >= ack_delay) begin
                dcnt    <= 0;
                phy_ack <= 1'b1;
                if (phy_req_addr) begin
                    cap_a <= phy_wdata;
                    stale <= 1'b1;
                end
                if (phy_req_data) cap_d <= phy_wdata;
                if (phy_req_rd) begin
                    phy_rdata <= stale ? 16'hBAD0 : mem[cap_a[5:0]];
                    stale     <= 1'b0;
                    rd_cnt    <= rd_cnt + 1;
                end
                if (phy_req_wr) begin
                    mem[cap_a[5:0]] <= cap_d;
                    wr_cnt <= wr_cnt + 1;
                end
            end else begin
                dcnt <= dcnt + 1;
            end
        end else if (phy_ack && !any_req) begin
            phy_ack <= 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #0.5;
        d = host_rdata;
    endtask

    task automatic wait_clear(input logic [5:0] a);
        logic [31:0] v;
        for (int i = 0; i < 500; i++) begin
            host_read(a, v);
            if (v == 0) return;
        end
        chk("R5 poll timeout", 32'd1, 32'd0);
    endtask

    task automatic phy_write(input logic [15:0] a, input logic [15:0] d);
        host_write(A_STAGE, {16'h0, a});
        host_write(A_CAPA, 1);
        wait_clear(A_CAPA);
        host_write(A_STAGE, {16'h0, d});
        host_write(A_CAPD, 1);
        wait_clear(A_CAPD);
        host_write(A_WR, 1);
        wait_clear(A_WR);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 requests", {28'h0, phy_req_addr, phy_req_data, phy_req_rd, phy_req_wr}, 0);
        host_read(A_RES, v);  chk("R1 result", v, 0);
        host_read(A_STAGE, v); chk("R1 stage", v, 0);
        host_read(A_RD, v);   chk("R1 read cmd", v, 0);
        host_read(A_WR, v);   chk("R1 write cmd", v, 0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        host_write(A_STAGE, 32'hFFFF_A5C3);
        host_read(A_STAGE, v); chk("R2 stage upper bits zero", v, 32'h0000_A5C3);
        chk("R7 phy_wdata follows stage", {16'h0, phy_wdata}, 32'h0000_A5C3);
        host_read(6'h04, v); chk("R2 unmapped offset", v, 0);
        host_read(6'h3C, v); chk("R2 unmapped offset high", v, 0);
    endtask

    task automatic t_start_edge();
        logic [31:0] v;
        ack_delay = 3;
        host_write(A_STAGE, 32'h1002);
        host_write(A_CAPA, 1);
        chk("R3 capa request next cycle",
            {28'h0, phy_req_addr, phy_req_data, phy_req_rd, phy_req_wr}, 32'h8);
        host_read(A_CAPA, v); chk("R5 capa busy", v, 1);
        wait_clear(A_CAPA);
        chk("R4 requests dropped", {31'h0, any_req}, 0);
        ack_delay = 1;
    endtask

    task automatic t_zero_cmd();
        logic [31:0] v;
        int r0 = rd_cnt;
        host_write(A_RD, 32'hFFFF_FFFE);
        chk("R10 no read request", {31'h0, phy_req_rd}, 0);
        host_read(A_RD, v); chk("R10 read cmd idle", v, 0);
        repeat (4) @(negedge clk);
        chk("R10 no read exchange", rd_cnt - r0, 0);
    endtask

    task automatic t_write_read();
        logic [31:0] v;
        int r0;
        phy_write(16'h1002, 16'h1234);
        phy_write(16'h1006, 16'hBEEF);
        chk("R3 write exchanges", wr_cnt, 2);
        host_write(A_STAGE, 32'h1002);
        host_write(A_CAPA, 1);
        wait_clear(A_CAPA);
        r0 = rd_cnt;
        host_write(A_RD, 1);
        wait_clear(A_RD);
        host_read(A_RES, v); chk("R9 stale answer discarded", v, 32'h1234);
        chk("R9 two read exchanges", rd_cnt - r0, 2);
        r0 = rd_cnt;
        host_write(A_RD, 1);
        wait_clear(A_RD);
        host_read(A_RES, v); chk("R8 second read value", v, 32'h1234);
        chk("R9 single read exchange", rd_cnt - r0, 1);
        host_write(A_STAGE, 32'h1006);
        host_write(A_CAPA, 1);
        wait_clear(A_CAPA);
        host_read(A_RES, v); chk("R8 result held over capture", v, 32'h1234);
        host_write(A_RD, 1);
        wait_clear(A_RD);
        host_read(A_RES, v); chk("R8 other address", v, 32'hBEEF);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        int r0 = rd_cnt;
        ack_delay = 10;
        host_write(A_STAGE, 32'h5555);
        host_write(A_CAPD, 1);
        host_write(A_RD, 1);
        host_read(A_RD, v); chk("R6 read cmd ignored while busy", v, 0);
        host_read(A_CAPD, v); chk("R5 capd still busy", v, 1);
        host_write(A_STAGE, 32'h7777);
        host_read(A_STAGE, v); chk("R7 stage write ignored while busy", v, 32'h5555);
        chk("R7 phy_wdata held", {16'h0, phy_wdata}, 32'h5555);
        wait_clear(A_CAPD);
        repeat (3) @(negedge clk);
        chk("R6 no read exchange after ignore", rd_cnt - r0, 0);
        ack_delay = 1;
    endtask

    task automatic t_collision();
        logic [31:0] v;
        int w0 = wr_cnt;
        ack_delay = 0;
        host_write(A_CAPA, 1);
        host_addr = A_CAPA;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            #0.5;
            if (!any_req && !phy_ack && host_rdata[0]) break;
        end
        host_we = 1'b1; host_addr = A_WR; host_wdata = 1;
        @(negedge clk);
        host_we = 1'b0;
        #0.5;
        chk("R6 collision no write request", {31'h0, phy_req_wr}, 0);
        host_read(A_WR, v); chk("R6 collision write cmd idle", v, 0);
        repeat (4) @(negedge clk);
        chk("R6 collision no write exchange", wr_cnt - w0, 0);
        ack_delay = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_start_edge();
        t_zero_cmd();
        t_write_read();
        t_busy_ignore();
        t_collision();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule